// File: doc/BRIEF.md
# Cache Victim Selector

This block decides which way of a set-associative cache set is to be replaced when a lookup misses. It holds replacement state for every set and offers four run-time policies: tree pseudo-LRU (which is exact LRU when the set has two ways), round-robin FIFO, a FIFO variant that never picks the most recently used way, and pseudo-random. The tag arrays, data arrays and refill logic live outside it. Each lookup outcome is reported to it with an access strobe, the set index, a hit flag and, on a hit, the hit way.

The victim for the presented set is available in the same cycle as the strobe. On a miss the block treats that victim as the way being filled, and it commits the replacement state at the next rising clock edge. All interfaces are plain strobes with no back-pressure: an access is consumed in the cycle it is presented. The number of sets and ways are parameters. Both are powers of two, with at least two sets and with 2 to 8 ways.

Top module: `victim_select`

## Requirements
- R1: After reset every set's state is cleared, so the first victim for any set is way 0 in modes 0, 1 and 2.
- R2: `victim_valid` is high exactly in cycles where `acc_valid` is high and `acc_hit` is low. In such a cycle `victim_way` holds the way to fill.
- R3: With `acc_valid` low, no replacement state changes, whatever the other inputs hold.
- R4: Mode 0 is tree pseudo-LRU. There are WAYS-1 node bits per set, heap-indexed with the root at node 1 and the children of node n at 2n and 2n+1. A node bit of 0 steers the victim search to the lower half and 1 to the upper half. Every access sets the bits on the path to the touched way so they point away from it. The touched way is the hit way, or the victim on a miss. The tree is updated on every access in every mode, and with two ways it is exact LRU.
- R5: Mode 1 is FIFO. The victim is the set's pointer. Each miss moves the pointer to the victim plus one, wrapping from the last way to way 0, and hits leave it unchanged.
- R6: Mode 2 is NMRU. It works like mode 1, except that when the pointer equals the set's recorded most recently used way the victim is the next way. The most recently used way is written on every access in every mode, and no way counts as most recently used until the set's first access.
- R7: Mode 3 is random. The victim is the low log2(WAYS) bits of a free-running 16-bit shift register. The register is loaded with the seed (default 16'hACE1) at reset and shifts left every clock, taking bit15^bit13^bit12^bit10 into bit 0.
- R8: Accesses to one set do not alter the victim choice of any other set.
- R9: The FIFO/NMRU pointer moves only on misses in modes 1 and 2. Accesses in modes 0 and 3 leave it as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Policy: 0 tree PLRU, 1 FIFO, 2 NMRU, 3 random |
| acc_valid | input | 1 | Access strobe, one lookup outcome per cycle |
| acc_set | input | log2(SETS) | Set index of the access |
| acc_hit | input | 1 | High when the lookup hit |
| acc_way | input | log2(WAYS) | Hit way, used only when `acc_hit` is high |
| victim_way | output | log2(WAYS) | Way to replace in the presented set under the current mode |
| victim_valid | output | 1 | High when a replacement is being committed (miss) |

## Verification
Any corrupted replacement state shows up only when the affected set next misses. At that point it appears at `victim_way` in the same cycle as the strobe: a tree bit pointing the wrong way returns the way just touched, and a pointer that failed to move repeats the previous victim. The bench therefore replays interleaved hit and miss sequences on single sets, with the expected victim worked out for each step. It also checks that other sets and idle cycles leave the state intact, and that a later miss still reveals any stale pointer, tree bit or MRU mark within a single access.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  typedef enum logic [1:0] {
    POL_PLRU = 2'd0,
    POL_FIFO = 2'd1,
    POL_NMRU = 2'd2,
    POL_RAND = 2'd3
  } pol_e;
endpackage

// File: rtl/vsel_plru.sv
// Tree pseudo-LRU: victim walk from the root and path update for a touched way.
// Node n lives at bit n of the tree vector; bit 0 is unused.
module vsel_plru #(
  parameter int WAYS = 4,
  localparam int LW = $clog2(WAYS)
) (
  input  logic [WAYS-1:0] tree_i,
  input  logic [LW-1:0]   touch_i,
  output logic [LW-1:0]   victim_o,
  output logic [WAYS-1:0] tree_o
);
  logic [2*WAYS-1:0] tree_pad;
  assign tree_pad = {{WAYS{1'b0}}, tree_i};

  always_comb begin
    logic [LW:0] node;
    node = (LW+1)'(1);
    for (int lvl = 0; lvl < LW; lvl++) begin
      node = {node[LW-1:0], tree_pad[node]};
    end
    victim_o = node[LW-1:0];
  end

  always_comb begin
    logic [LW:0] path;
    logic [LW:0] node;
    path   = {1'b1, touch_i};
    tree_o = tree_i;
    for (int lvl = 0; lvl < LW; lvl++) begin
      node = path >> (LW - lvl);
      tree_o[node[LW-1:0]] = ~touch_i[LW-1-lvl];
    end
  end
endmodule

// File: rtl/vsel_rr.sv
// Round-robin pick with optional skip of the most recently used way.
module vsel_rr #(
  parameter int WAYS = 4,
  localparam int LW = $clog2(WAYS)
) (
  input  logic [LW-1:0] ptr_i,
  input  logic [LW-1:0] mru_i,
  input  logic          mru_vld_i,
  input  logic          skip_en_i,
  output logic [LW-1:0] pick_o
);
  always_comb begin
    if (skip_en_i && mru_vld_i && (ptr_i == mru_i)) pick_o = ptr_i + 1'b1;
    else                                             pick_o = ptr_i;
  end
endmodule

// File: rtl/vsel_lfsr.sv
// Free-running 16-bit Fibonacci shift register, low bits exported.
module vsel_lfsr #(
  parameter logic [15:0] SEED  = 16'hACE1,
  parameter int          OUT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd_o
);
  logic [15:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= SEED;
    else        sr_q <= {sr_q[14:0], sr_q[15] ^ sr_q[13] ^ sr_q[12] ^ sr_q[10]};
  end

  assign rnd_o = sr_q[OUT_W-1:0];
endmodule

// File: rtl/victim_select.sv
module victim_select
  import vsel_pkg::*;
#(
  parameter int          SETS      = 64,
  parameter int          WAYS      = 4,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int         SW        = $clog2(SETS),
  localparam int         LW        = $clog2(WAYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          acc_valid,
  input  logic [SW-1:0] acc_set,
  input  logic          acc_hit,
  input  logic [LW-1:0] acc_way,
  output logic [LW-1:0] victim_way,
  output logic          victim_valid
);
  pol_e pol;
  assign pol = pol_e'(mode);

  logic [WAYS-1:0] tree_q [SETS];
  logic [LW-1:0]   ptr_q  [SETS];
  logic [LW-1:0]   mru_q  [SETS];
  logic [SETS-1:0] mvld_q;

  logic [WAYS-1:0] tree_cur, tree_nxt;
  logic [LW-1:0]   plru_vic, rr_vic, rnd_vic, pick, touch;
  logic            rr_mode;

  assign tree_cur = tree_q[acc_set];
  assign rr_mode  = (pol == POL_FIFO) || (pol == POL_NMRU);

  vsel_plru #(.WAYS(WAYS)) plru_i (
    .tree_i   (tree_cur),
    .touch_i  (touch),
    .victim_o (plru_vic),
    .tree_o   (tree_nxt)
  );

  vsel_rr #(.WAYS(WAYS)) rr_i (
    .ptr_i     (ptr_q[acc_set]),
    .mru_i     (mru_q[acc_set]),
    .mru_vld_i (mvld_q[acc_set]),
    .skip_en_i (pol == POL_NMRU),
    .pick_o    (rr_vic)
  );

  vsel_lfsr #(.SEED(LFSR_SEED), .OUT_W(LW)) lfsr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .rnd_o (rnd_vic)
  );

  always_comb begin
    case (pol)
      POL_PLRU:           pick = plru_vic;
      POL_FIFO, POL_NMRU: pick = rr_vic;
      default:            pick = rnd_vic;
    endcase
  end

  assign touch        = acc_hit ? acc_way : pick;
  assign victim_way   = pick;
  assign victim_valid = acc_valid & ~acc_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        tree_q[s] <= '0;
        ptr_q[s]  <= '0;
        mru_q[s]  <= '0;
      end
      mvld_q <= '0;
    end else if (acc_valid) begin
      tree_q[acc_set] <= tree_nxt;
      mru_q[acc_set]  <= touch;
      mvld_q[acc_set] <= 1'b1;
      if (!acc_hit && rr_mode) ptr_q[acc_set] <= pick + 1'b1;
    end
  end
endmodule

module vsel_chk #(
  parameter int  SETS = 64,
  parameter int  WAYS = 4,
  localparam int SW   = $clog2(SETS),
  localparam int LW   = $clog2(WAYS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          acc_valid,
  input logic [SW-1:0] acc_set,
  input logic          acc_hit,
  input logic [LW-1:0] acc_way,
  input logic [LW-1:0] victim_way,
  input logic          victim_valid
);
  logic          armed, prev_acc, prev_fifo_miss;
  logic [SW-1:0] prev_set;
  logic [LW-1:0] prev_touch, prev_vic;
  logic          miss_now;

  assign miss_now = acc_valid && !acc_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; prev_acc <= 1'b0; prev_fifo_miss <= 1'b0;
      prev_set <= '0; prev_touch <= '0; prev_vic <= '0;
    end else begin
      armed          <= 1'b1;
      prev_acc       <= acc_valid;
      prev_fifo_miss <= miss_now && (mode == 2'd1);
      prev_set       <= acc_set;
      prev_touch     <= acc_hit ? acc_way : victim_way;
      prev_vic       <= victim_way;
    end
  end

  // R2
  vv_only_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> (acc_valid && !acc_hit));

  // R2
  vv_on_every_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_now |-> victim_valid);

  // R4
  plru_avoids_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && prev_acc && prev_set == acc_set && miss_now && mode == 2'd0)
      |-> victim_way != prev_touch);

  // R5
  fifo_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && prev_fifo_miss && prev_set == acc_set && miss_now && mode == 2'd1)
      |-> victim_way == LW'(prev_vic + 1'b1));

  // R6
  nmru_skips_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && prev_acc && prev_set == acc_set && miss_now && mode == 2'd2)
      |-> victim_way != prev_touch);
endmodule

bind victim_select vsel_chk #(.SETS(SETS), .WAYS(WAYS)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode         (mode),
  .acc_valid    (acc_valid),
  .acc_set      (acc_set),
  .acc_hit      (acc_hit),
  .acc_way      (acc_way),
  .victim_way   (victim_way),
  .victim_valid (victim_valid)
);

// File: tb/victim_select_tb.sv
module victim_select_tb_top;
  localparam int SETS = 4;
  localparam int WAYS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       acc_valid = 1'b0;
  logic [1:0] acc_set = '0;
  logic       acc_hit = 1'b0;
  logic [1:0] acc_way = '0;
  logic [1:0] victim_way;
  logic       victim_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  victim_select #(.SETS(SETS), .WAYS(WAYS)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .acc_valid(acc_valid),
    .acc_set(acc_set), .acc_hit(acc_hit), .acc_way(acc_way),
    .victim_way(victim_way), .victim_valid(victim_valid)
  );

  // Model of the random source as the requirement states it (R7)
  logic [15:0] rmodel;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rmodel <= 16'hACE1;
    else        rmodel <= {rmodel[14:0], rmodel[15] ^ rmodel[13] ^ rmodel[12] ^ rmodel[10]};
  end

  typedef struct packed {
    logic [1:0] md;
    logic [1:0] st;
    logic       v;
    logic       h;
    logic [1:0] w;
    logic       ev;
    logic [1:0] ex;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b1, 2'd0, 4'd4},  // R4 fresh tree
    '{2'd0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b1, 2'd2, 4'd4},
    '{2'd0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b1, 2'd1, 4'd4},
    '{2'd0, 2'd0, 1'b1, 1'b1, 2'd3, 1'b0, 2'd0, 4'd4},  // R4 hit way 3
    '{2'd0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b1, 2'd0, 4'd4},
    '{2'd0, 2'd0, 1'b1, 1'b1, 2'd2, 1'b0, 2'd0, 4'd4},
    '{2'd0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b1, 2'd1, 4'd4},
    '{2'd0, 2'd1, 1'b1, 1'b0, 2'd0, 1'b1, 2'd0, 4'd8},  // R8 other set untouched
    '{2'd0, 2'd1, 1'b1, 1'b0, 2'd0, 1'b1, 2'd2, 4'd8},
    '{2'd1, 2'd2, 1'b1, 1'b0, 2'd0, 1'b1, 2'd0, 4'd5},  // R5 FIFO
    '{2'd1, 2'd2, 1'b1, 1'b1, 2'd3, 1'b0, 2'd0, 4'd5},  // R5 hit keeps pointer
    '{2'd1, 2'd2, 1'b1, 1'b0, 2'd0, 1'b1, 2'd1, 4'd5},
    '{2'd1, 2'd2, 1'b1, 1'b0, 2'd0, 1'b1, 2'd2, 4'd5},
    '{2'd1, 2'd2, 1'b1, 1'b0, 2'd0, 1'b1, 2'd3, 4'd5},
    '{2'd1, 2'd2, 1'b1, 1'b0, 2'd0, 1'b1, 2'd0, 4'd5},  // R5 wrap
    '{2'd1, 2'd2, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 4'd3},  // R3 idle miss-like input
    '{2'd1, 2'd2, 1'b1, 1'b0, 2'd0, 1'b1, 2'd1, 4'd3},  // R3 pointer unchanged
    '{2'd2, 2'd3, 1'b1, 1'b0, 2'd0, 1'b1, 2'd0, 4'd6},  // R6 no MRU yet
    '{2'd2, 2'd3, 1'b1, 1'b1, 2'd1, 1'b0, 2'd0, 4'd6},
    '{2'd2, 2'd3, 1'b1, 1'b0, 2'd0, 1'b1, 2'd2, 4'd6},  // R6 skip way 1
    '{2'd2, 2'd3, 1'b1, 1'b1, 2'd3, 1'b0, 2'd0, 4'd6},
    '{2'd2, 2'd3, 1'b1, 1'b0, 2'd0, 1'b1, 2'd0, 4'd6},  // R6 skip with wrap
    '{2'd2, 2'd3, 1'b1, 1'b0, 2'd0, 1'b1, 2'd1, 4'd6},
    '{2'd1, 2'd0, 1'b1, 1'b0, 2'd0, 1'b1, 2'd0, 4'd9}   // R9 PLRU misses left pointer
  };

  function automatic string rtag(input int n);
    case (n)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic do_reset;
    acc_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state in every set for modes 0..2, no strobe
    @(negedge clk);
    for (int m = 0; m < 3; m++) begin
      for (int s = 0; s < SETS; s++) begin
        mode = 2'(m); acc_set = 2'(s); acc_valid = 1'b0; acc_hit = 1'b0;
        #1;
        check("R1", victim_way, 0, "first victim after reset");
        check("R2", victim_valid, 0, "no strobe");
      end
    end

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode = VEC[i].md; acc_set = VEC[i].st; acc_valid = VEC[i].v;
      acc_hit = VEC[i].h; acc_way = VEC[i].w;
      #1;
      check(rtag(2), victim_valid, VEC[i].ev, $sformatf("victim_valid vec %0d", i));
      if (VEC[i].ev) check(rtag(int'(VEC[i].rq)), victim_way, VEC[i].ex, $sformatf("victim vec %0d", i));
    end

    // R1 mid-run reset clears every kind of state
    do_reset();
    @(negedge clk);
    mode = 2'd0; acc_set = 2'd0; acc_valid = 1'b0; #1;
    check("R1", victim_way, 0, "tree after second reset");
    mode = 2'd1; acc_set = 2'd2; #1;
    check("R1", victim_way, 0, "pointer after second reset");
    mode = 2'd2; acc_set = 2'd3; #1;
    check("R1", victim_way, 0, "nmru after second reset");

    // R7 random victims follow the shift register
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      mode = 2'd3; acc_set = 2'(k); acc_valid = 1'b1; acc_hit = 1'b0;
      #1;
      check("R7", victim_way, int'(rmodel[1:0]), $sformatf("random step %0d", k));
      check("R2", victim_valid, 1, "random miss strobe");
    end
    @(negedge clk);
    acc_valid = 1'b0;

    // R9 random-mode misses left set 2 pointer at 2 after the table walk? reset cleared it: expect 0
    @(negedge clk);
    mode = 2'd1; acc_set = 2'd2; #1;
    check("R9", victim_way, 0, "pointer after random misses");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule